// File: doc/BRIEF.md
# Operand-Capturing Reservation Station

This block holds up to four decoded operations in front of a single functional unit. Each accepted operation brings an opcode, a destination tag, a sequence number and two source operands. Each source either already carries its value or names the tag of the operation that will produce it. The station watches a result broadcast bus (valid, tag, value). Every waiting source whose tag matches a broadcast takes the value and becomes ready.

In every cycle the station looks at the occupied slots whose two sources are both ready. If the functional unit reports that it is free, the oldest of those slots, judged by sequence number, is presented on the issue port and its slot is released at the next edge. Issue follows operand readiness, not arrival order, so a later operation whose data is present can overtake an earlier one that is still waiting.

When all slots are occupied and nothing issues, a stall goes back to the dispatch side. A flush input removes every operation younger than a given sequence number. Renaming and the functional unit itself sit outside this block.

Top module: `rs_station`

## Requirements
- R1: After synchronous active-high reset all slots are empty: `iss_valid` is 0 and `disp_stall` is 0.
- R2: When `disp_valid` is 1 and `disp_stall` is 0, the operation is stored at the clock edge. Each source with its ready flag set stores its value. A source with its ready flag clear stores its tag and waits.
- R3: `iss_valid` is 1 in a cycle only when `fu_free` is 1 and at least one stored operation has both sources ready. An operation stored at edge N can issue no earlier than the cycle that follows edge N.
- R4: A `bc_valid` broadcast whose `bc_tag` equals the tag of a waiting source, in any slot, delivers `bc_val` to that source at the edge. The source counts as ready from the next cycle.
- R5: Among the ready slots, the issued one has the oldest sequence number. Sequence `a` is older than `b` when bit 5 of the 6-bit difference (a - b) mod 64 is 1, so the order carries across wrap-around. A ready younger operation issues ahead of an older one that is still waiting.
- R6: A broadcast in the same cycle as an accepted dispatch whose waiting source names the same tag is taken by the new slot, so that source is ready in the next cycle.
- R7: A slot is released at the edge that ends the cycle in which it issues, and that same cycle can accept a dispatch. `disp_stall` is 1 exactly when all four slots are occupied and `iss_valid` is 0. A dispatch offered while `disp_stall` is 1 is dropped.
- R8: `flush_valid` removes, at the edge, every stored operation whose sequence number is strictly younger than `flush_seq`. This includes an operation dispatched in that same cycle. Operations that are older than or equal to `flush_seq` stay.
- R9: While `iss_valid` is 1, `iss_op`, `iss_dtag` and `iss_seq` carry the selected operation's fields, `iss_a` carries its first source value and `iss_b` carries its second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 4 | Opcode of the dispatched operation |
| disp_dtag | input | 4 | Destination tag |
| disp_seq | input | 6 | Sequence number (age) |
| disp_a_rdy | input | 1 | First source holds a value |
| disp_a_tag | input | 4 | First source producer tag |
| disp_a_val | input | 16 | First source value |
| disp_b_rdy | input | 1 | Second source holds a value |
| disp_b_tag | input | 4 | Second source producer tag |
| disp_b_val | input | 16 | Second source value |
| disp_stall | output | 1 | Station full and not issuing |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 4 | Broadcast result tag |
| bc_val | input | 16 | Broadcast result value |
| flush_valid | input | 1 | Remove younger operations |
| flush_seq | input | 6 | Flush boundary sequence number |
| fu_free | input | 1 | Functional unit can accept an operation |
| iss_valid | output | 1 | Operation issued this cycle |
| iss_op | output | 4 | Issued opcode |
| iss_dtag | output | 4 | Issued destination tag |
| iss_seq | output | 6 | Issued sequence number |
| iss_a | output | 16 | Issued first operand |
| iss_b | output | 16 | Issued second operand |

## Verification
The hardest case to reach from the ports is a full station that issues and accepts a new dispatch in the same cycle, where the slot being released is the one that gets written. Random traffic seldom makes that happen at the moment of interest. The bench therefore fills all four slots with waiting operations while the unit is busy, wakes exactly one of them, and then offers a dispatch in the cycle the unit frees up. Directed steps also cover a dispatch that meets its producer's broadcast in the same cycle, and sequence numbers that wrap past 63 to 0. Random traffic with occasional flushes covers the rest.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int NSLOT  = 4;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int SEQ_W  = 6;
    localparam int IDX_W  = $clog2(NSLOT);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;
    typedef logic [SEQ_W-1:0]  seq_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } src_t;

    typedef struct packed {
        logic  valid;
        op_t   op;
        tag_t  dtag;
        seq_t  seq;
        src_t  sa;
        src_t  sb;
    } entry_t;

    // a is older than b under modular sequence ordering
    function automatic logic seq_older(seq_t a, seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction

    // capture a broadcast result into a waiting source
    function automatic src_t snoop(src_t s, logic bv, tag_t bt, data_t bd);
        src_t r;
        r = s;
        if (bv && !s.rdy && (s.tag == bt)) begin
            r.rdy = 1'b1;
            r.val = bd;
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  entry_t wr_entry,
    input  logic   clr,
    input  logic   bc_valid,
    input  tag_t   bc_tag,
    input  data_t  bc_val,
    input  logic   flush_valid,
    input  seq_t   flush_seq,
    output entry_t q,
    output logic   ready
);

    entry_t nxt;

    always_comb begin
        nxt = q;
        if (clr)   nxt.valid = 1'b0;
        if (wr_en) nxt = wr_entry;
        nxt.sa = snoop(nxt.sa, bc_valid, bc_tag, bc_val);
        nxt.sb = snoop(nxt.sb, bc_valid, bc_tag, bc_val);
        if (flush_valid && seq_older(flush_seq, nxt.seq)) nxt.valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign ready = q.valid && q.sa.rdy && q.sb.rdy;

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick
    import rs_pkg::*;
(
    input  logic [NSLOT-1:0] req,
    input  seq_t             seqs [NSLOT],
    output logic [NSLOT-1:0] gnt
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
        always_comb begin
            logic win;
            win = req[i];
            for (int j = 0; j < NSLOT; j++) begin
                if (j != i && req[j] && !seq_older(seqs[i], seqs[j])) win = 1'b0;
            end
            gnt[i] = win;
        end
    end

endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick
    import rs_pkg::*;
(
    input  logic [NSLOT-1:0] avail,
    output logic [NSLOT-1:0] sel
);

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (avail[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dtag,
    input  logic [SEQ_W-1:0]  disp_seq,
    input  logic              disp_a_rdy,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic [DATA_W-1:0] disp_a_val,
    input  logic              disp_b_rdy,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic [DATA_W-1:0] disp_b_val,
    output logic              disp_stall,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              flush_valid,
    input  logic [SEQ_W-1:0]  flush_seq,
    input  logic              fu_free,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dtag,
    output logic [SEQ_W-1:0]  iss_seq,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);

    entry_t           slots    [NSLOT];
    seq_t             slot_seq [NSLOT];
    logic [NSLOT-1:0] slot_valid;
    logic [NSLOT-1:0] slot_rdy;
    logic [NSLOT-1:0] oldest;
    logic [NSLOT-1:0] grant;
    logic [NSLOT-1:0] wr_sel;
    logic             disp_fire;
    entry_t           incoming;

    always_comb begin
        incoming.valid  = 1'b1;
        incoming.op     = disp_op;
        incoming.dtag   = disp_dtag;
        incoming.seq    = disp_seq;
        incoming.sa.rdy = disp_a_rdy;
        incoming.sa.tag = disp_a_tag;
        incoming.sa.val = disp_a_rdy ? disp_a_val : '0;
        incoming.sb.rdy = disp_b_rdy;
        incoming.sb.tag = disp_b_tag;
        incoming.sb.val = disp_b_rdy ? disp_b_val : '0;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        rs_slot slot_i (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (disp_fire && wr_sel[i]),
            .wr_entry   (incoming),
            .clr        (grant[i]),
            .bc_valid   (bc_valid),
            .bc_tag     (bc_tag),
            .bc_val     (bc_val),
            .flush_valid(flush_valid),
            .flush_seq  (flush_seq),
            .q          (slots[i]),
            .ready      (slot_rdy[i])
        );
        assign slot_valid[i] = slots[i].valid;
        assign slot_seq[i]   = slots[i].seq;
    end

    rs_age_pick age_i (
        .req (slot_rdy),
        .seqs(slot_seq),
        .gnt (oldest)
    );

    assign grant     = fu_free ? oldest : '0;
    assign iss_valid = |grant;
    assign disp_stall = (&slot_valid) && !iss_valid;
    assign disp_fire  = disp_valid && !disp_stall;

    rs_free_pick free_i (
        .avail(~slot_valid | grant),
        .sel  (wr_sel)
    );

    always_comb begin
        iss_op   = '0;
        iss_dtag = '0;
        iss_seq  = '0;
        iss_a    = '0;
        iss_b    = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (grant[i]) begin
                iss_op   = slots[i].op;
                iss_dtag = slots[i].dtag;
                iss_seq  = slots[i].seq;
                iss_a    = slots[i].sa.val;
                iss_b    = slots[i].sb.val;
            end
        end
    end

endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             disp_valid,
    input logic             disp_stall,
    input logic             flush_valid,
    input logic             fu_free,
    input logic             iss_valid,
    input logic [NSLOT-1:0] slot_valid,
    input logic [NSLOT-1:0] grant
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!iss_valid && !disp_stall));

    // R3
    issue_needs_unit_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> fu_free);

    // R3
    grant_in_occupied_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~slot_valid) == '0);

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R7
    stall_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> ((&slot_valid) && !iss_valid));

    // R2
    accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_stall && !flush_valid) |=> (|slot_valid));

endmodule

bind rs_station rs_station_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_stall (disp_stall),
    .flush_valid(flush_valid),
    .fu_free    (fu_free),
    .iss_valid  (iss_valid),
    .slot_valid (slot_valid),
    .grant      (grant)
);

// File: tb/rs_station_tb_top.sv
`timescale 1ns/1ps
module rs_station_tb_top;
    import rs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic  d_valid = 0, d_r0 = 0, d_r1 = 0;
    op_t   d_op = '0;
    tag_t  d_dtag = '0, d_t0 = '0, d_t1 = '0;
    seq_t  d_seq = '0;
    data_t d_v0 = '0, d_v1 = '0;
    logic  bc_v = 0;
    tag_t  bc_t = '0;
    data_t bc_d = '0;
    logic  fl_v = 0;
    seq_t  fl_seq = '0;
    logic  fu_free = 0;

    logic  disp_stall, iss_valid;
    op_t   iss_op;
    tag_t  iss_dtag;
    seq_t  iss_seq;
    data_t iss_a, iss_b;

    rs_station dut_i (
        .clk(clk), .rst(rst),
        .disp_valid(d_valid), .disp_op(d_op), .disp_dtag(d_dtag), .disp_seq(d_seq),
        .disp_a_rdy(d_r0), .disp_a_tag(d_t0), .disp_a_val(d_v0),
        .disp_b_rdy(d_r1), .disp_b_tag(d_t1), .disp_b_val(d_v1),
        .disp_stall(disp_stall),
        .bc_valid(bc_v), .bc_tag(bc_t), .bc_val(bc_d),
        .flush_valid(fl_v), .flush_seq(fl_seq), .fu_free(fu_free),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dtag(iss_dtag),
        .iss_seq(iss_seq), .iss_a(iss_a), .iss_b(iss_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    seq_t next_seq = '0;

    // bench model: unordered pool of four entries
    logic  m_v  [4];
    op_t   m_op [4];
    tag_t  m_dt [4];
    seq_t  m_sq [4];
    logic  m_r0 [4], m_r1 [4];
    tag_t  m_t0 [4], m_t1 [4];
    data_t m_a  [4], m_b  [4];

    function automatic bit older(seq_t a, seq_t b);
        logic [5:0] d;
        d = a - b;
        return d[5];
    endfunction

    task automatic check(bit ok, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle();
        d_valid = 0; bc_v = 0; fl_v = 0;
    endtask

    task automatic disp_set(op_t op, tag_t dt, logic r0, tag_t t0, data_t v0,
                            logic r1, tag_t t1, data_t v1);
        d_valid = 1; d_op = op; d_dtag = dt; d_seq = next_seq;
        d_r0 = r0; d_t0 = t0; d_v0 = v0;
        d_r1 = r1; d_t1 = t1; d_v1 = v1;
    endtask

    task automatic bcast(tag_t t, data_t v);
        bc_v = 1; bc_t = t; bc_d = v;
    endtask

    // check outputs for the current cycle, then advance the model over one edge
    task automatic step(string ctx);
        int  cnt, sel;
        bit  ev, est, fire;
        #1;
        cnt = 0; sel = -1;
        for (int i = 0; i < 4; i++) begin
            if (m_v[i]) cnt++;
            if (m_v[i] && m_r0[i] && m_r1[i]) begin
                if (sel < 0 || older(m_sq[i], m_sq[sel])) sel = i;
            end
        end
        ev  = fu_free && (sel >= 0);
        est = (cnt == 4) && !ev;
        check(iss_valid == ev, {"R3 iss_valid [", ctx, "]"}, iss_valid, ev);
        check(disp_stall == est, {"R7 disp_stall [", ctx, "]"}, disp_stall, est);
        if (ev && iss_valid) begin
            check(iss_seq == m_sq[sel], {"R5 iss_seq [", ctx, "]"}, iss_seq, m_sq[sel]);
            check(iss_op == m_op[sel] && iss_dtag == m_dt[sel],
                  {"R9 iss_op/dtag [", ctx, "]"}, {iss_op, iss_dtag}, {m_op[sel], m_dt[sel]});
            check(iss_a == m_a[sel] && iss_b == m_b[sel],
                  {"R9 operands [", ctx, "]"}, {iss_a, iss_b}, {m_a[sel], m_b[sel]});
        end
        @(posedge clk);
        fire = d_valid && !est;
        if (ev) m_v[sel] = 0;
        if (fire) begin
            int k;
            k = -1;
            for (int i = 0; i < 4; i++) if (!m_v[i] && k < 0) k = i;
            m_v[k] = 1; m_op[k] = d_op; m_dt[k] = d_dtag; m_sq[k] = d_seq;
            m_r0[k] = d_r0; m_t0[k] = d_t0; m_a[k] = d_r0 ? d_v0 : '0;
            m_r1[k] = d_r1; m_t1[k] = d_t1; m_b[k] = d_r1 ? d_v1 : '0;
            next_seq = next_seq + 1;
        end
        for (int i = 0; i < 4; i++) begin
            if (bc_v && !m_r0[i] && m_t0[i] == bc_t) begin m_r0[i] = 1; m_a[i] = bc_d; end
            if (bc_v && !m_r1[i] && m_t1[i] == bc_t) begin m_r1[i] = 1; m_b[i] = bc_d; end
            if (fl_v && older(fl_seq, m_sq[i])) m_v[i] = 0;
        end
        if (fl_v) next_seq = fl_seq + 1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 0; m_r0[i] = 1; m_r1[i] = 1; m_sq[i] = '0;
            m_t0[i] = '0; m_t1[i] = '0; m_a[i] = '0; m_b[i] = '0;
            m_op[i] = '0; m_dt[i] = '0;
        end
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        step("R1 reset state");

        // R6: dispatch meets its producer's broadcast in the same cycle
        fu_free = 0;
        disp_set(4'h3, 4'h1, 0, 4'h5, '0, 1, 4'h0, 16'h0022);
        bcast(4'h5, 16'h1234);
        step("R6 dispatch with same-tag broadcast");
        idle(); fu_free = 1;
        step("R6 captured value issues");
        step("R6 station empty");

        // R5 younger ready passes older waiting; R4 wakeup timing
        fu_free = 0;
        disp_set(4'h1, 4'h2, 0, 4'h7, '0, 1, 4'h0, 16'h0001);
        step("R2 older waiting dispatch");
        disp_set(4'h2, 4'h3, 1, 4'h0, 16'h00aa, 1, 4'h0, 16'h00bb);
        step("R2 younger ready dispatch");
        idle(); fu_free = 1;
        step("R5 younger overtakes older");
        bcast(4'h7, 16'hbeef);
        step("R4 broadcast cycle no issue yet");
        idle();
        step("R4 woken operation issues");
        step("R4 empty again");

        // R7 fill, stall, drop, then issue-and-refill in one cycle
        fu_free = 0;
        for (int i = 0; i < 4; i++) begin
            disp_set(op_t'(i), tag_t'(i + 4), 0, tag_t'(8 + i), '0, 1, 4'h0, data_t'(i));
            step("R7 fill");
        end
        disp_set(4'hf, 4'hf, 1, 4'h0, 16'h5555, 1, 4'h0, 16'h6666);
        step("R7 dispatch while stalled is dropped");
        idle(); bcast(4'h9, 16'h0909);
        step("R7 wake one while busy");
        idle(); fu_free = 1;
        disp_set(4'he, 4'he, 1, 4'h0, 16'h7777, 1, 4'h0, 16'h8888);
        step("R7 issue frees slot and accepts dispatch");
        idle();
        step("R7 new entry issues");
        bcast(4'h8, 16'h0808); step("R2 drain");
        bcast(4'ha, 16'h0a0a); step("R2 drain");
        bcast(4'hb, 16'h0b0b); step("R2 drain");
        idle();
        repeat (3) step("R2 drain");

        // R8 flush removes strictly younger entries
        fu_free = 0;
        for (int i = 0; i < 4; i++) begin
            disp_set(4'h4, tag_t'(i), 0, tag_t'(i + 1), '0, 1, 4'h0, 16'h0100);
            step("R8 fill");
        end
        idle(); fl_v = 1; fl_seq = next_seq - 3;
        step("R8 flush");
        idle(); fu_free = 1;
        for (int i = 0; i < 4; i++) begin
            bcast(tag_t'(i + 1), data_t'(16'h2000 + i));
            step("R8 only survivors issue");
        end
        idle();
        repeat (3) step("R8 empty after flush");

        // R5 wrap-around ordering
        next_seq = 6'd62; fu_free = 0;
        for (int i = 0; i < 4; i++) begin
            disp_set(op_t'(i), tag_t'(i), 1, 4'h0, data_t'(i * 3), 1, 4'h0, data_t'(i * 5));
            step("R5 wrap fill");
        end
        idle(); fu_free = 1;
        repeat (5) step("R5 wrap order");

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            idle();
            fu_free = ($urandom % 4) != 0;
            if ($urandom % 2)
                disp_set(op_t'($urandom), tag_t'($urandom),
                         ($urandom % 2) == 0, tag_t'($urandom), data_t'($urandom),
                         ($urandom % 2) == 0, tag_t'($urandom), data_t'($urandom));
            if ($urandom % 2) bcast(tag_t'($urandom), data_t'($urandom));
            if ($urandom % 50 == 0) begin
                fl_v = 1;
                fl_seq = next_seq - 1 - seq_t'($urandom % 3);
            end
            step("R2 random");
        end
        idle();
        step("R2 random end");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule